// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block holds the byte-wide configuration registers of a legacy two-channel disk-interface controller. A host reaches them through a pair of I/O ports. The host first writes an 8-bit register index to the index port at offset 0. It then reads or writes the selected byte through the data port at offset `DATA_OFS`, which defaults to 4. The index stays latched, so the same register can be accessed again without rewriting it.

The bank holds eleven registers:

- a configuration byte, whose revision, primary-interrupt and port-location bits are read-only;
- a control byte carrying the second-channel enable, the read-ahead disables for drives 0 and 1, and the fast device-select timing bits;
- a command-timing byte;
- an address-setup byte and a read/write-timing byte for drive 0, for drive 1 and for the shared drive-2/3 pair;
- a burst-size byte;
- a scratch byte that software uses to check that the part is present.

The stored fields drive the rest of the controller directly through the block's outputs.

Top module: `ide_cfg_port`

## Requirements
- R1: A write at bus offset 0 latches `bus_wdata` as the register index. A read at offset 0 returns the latched index.
- R2: The configuration byte is at index 0x50. It reads back as follows:
  - bits 1:0 return parameter `REVISION` (default 2);
  - bit 2 returns input `irq_pri`;
  - bit 5 returns parameter `ALT_LOC` (default 0);
  - bits 7:6 and 4:3 are read/write.
  Host writes to bits 5 and 2:0 have no effect.
- R3: The control byte is at index 0x51 and is read/write. `chan2_en` follows its bit 3. `prefetch_off[0]` follows bit 6 and `prefetch_off[1]` follows bit 7.
- R4: `fast_devsel` is 1 exactly when control bits 5, 2, 1 and 0 (mask 0x27) are all set.
- R5: Indices 0x52 to 0x58 are read/write timing bytes, exported as follows:
  - `cmd_timing` is the byte at 0x52;
  - `drv_setup` is {0x57, 0x55, 0x53};
  - `drv_rw` is {0x58, 0x56, 0x54}.
  Drive 0 occupies the low byte of `drv_setup` and `drv_rw`.
- R6: In byte 0x57, bits 2 and 3 drive `prefetch_off[2]` and `prefetch_off[3]`. Bit 4 reads input `irq_sec` and ignores host writes.
- R7: The burst byte at index 0x59 is read/write and resets to `BURST_RST` (default 0x40). It is exported on `burst_size`.
- R8: Index 0x5B is a scratch byte that returns the last value written to it, for example 0xBD.
- R9: Unimplemented indices read 0x00. Examples are 0x00, 0x5A and 0xFF. A write to such an index changes no register.
- R10: After reset the following are all 0: every register except the burst byte, the latched index, and `bus_rdata`.
- R11: `bus_rdata` is registered. It shows the read result in the cycle after `bus_rd` and is 0x00 in any cycle after no read. Offsets other than 0 and `DATA_OFS` read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Port offset from the base address |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered read data |
| irq_pri | input | 1 | Primary-channel interrupt status |
| irq_sec | input | 1 | Secondary-channel interrupt status |
| cmd_timing | output | 8 | Command timing byte |
| drv_setup | output | 24 | Address-setup bytes for drive 0, drive 1 and drives 2/3 |
| drv_rw | output | 24 | Read/write timing bytes for drive 0, drive 1 and drives 2/3 |
| burst_size | output | 8 | Burst-size byte |
| prefetch_off | output | 4 | Per-drive read-ahead disable |
| chan2_en | output | 1 | Second-channel enable |
| fast_devsel | output | 1 | Fast device-select host timing |

## Verification
The bench uses the default parameters:

- a 3-bit offset with the data port at 4;
- revision 2;
- location flag 0;
- burst reset 0x40;
- the scratch register built in.

The revision value, a non-zero, non-all-ones pattern, shows that the read-only overlay replaces written bits instead of merging them. Built this way, the scratch and burst reset paths can be reached. The three-bit offset leaves spare offsets such as 2, so the bench can confirm that stray port accesses disturb neither the index nor the data.

// File: rtl/ide_cfg_pkg.sv
package ide_cfg_pkg;

   localparam int unsigned NUM_BANK    = 10;
   localparam logic [7:0]  BANK_BASE   = 8'h50;
   localparam logic [7:0]  SCRATCH_IDX = 8'h5B;

   localparam int unsigned OFS_CFG   = 0;
   localparam int unsigned OFS_CTRL  = 1;
   localparam int unsigned OFS_CMD   = 2;
   localparam int unsigned OFS_SU0   = 3;
   localparam int unsigned OFS_RW0   = 4;
   localparam int unsigned OFS_SU1   = 5;
   localparam int unsigned OFS_RW1   = 6;
   localparam int unsigned OFS_SU23  = 7;
   localparam int unsigned OFS_RW23  = 8;
   localparam int unsigned OFS_BURST = 9;

   localparam logic [7:0] FAST_DEVSEL_MASK = 8'h27;

   typedef enum logic [1:0] {
      PORT_NONE  = 2'd0,
      PORT_INDEX = 2'd1,
      PORT_DATA  = 2'd2
   } port_sel_e;

   // host-writable bits of each bank byte; the rest are overlaid on read
   function automatic logic [7:0] bank_wmask(input int unsigned ofs);
      case (ofs)
         OFS_CFG:  return 8'hD8;
         OFS_SU23: return 8'hEF;
         default:  return 8'hFF;
      endcase
   endfunction

   function automatic logic [7:0] bank_reset(input int unsigned ofs,
                                             input logic [7:0] burst_rst);
      return (ofs == OFS_BURST) ? burst_rst : 8'h00;
   endfunction

endpackage

// File: rtl/ide_cfg_index.sv
module ide_cfg_index
   import ide_cfg_pkg::*;
#(
   parameter int unsigned ADDR_W   = 3,
   parameter int unsigned DATA_OFS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output port_sel_e         sel,
   output logic [7:0]        idx,
   output logic              data_wr
);

   localparam logic [ADDR_W-1:0] IDX_ADDR  = '0;
   localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(DATA_OFS);

   always_comb begin
      if (bus_addr == IDX_ADDR)       sel = PORT_INDEX;
      else if (bus_addr == DATA_ADDR) sel = PORT_DATA;
      else                            sel = PORT_NONE;
   end

   assign data_wr = bus_wr && (sel == PORT_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             idx <= 8'h00;
      else if (bus_wr && sel == PORT_INDEX)   idx <= bus_wdata;
   end

   AST_IDX_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == IDX_ADDR) |=> idx == $past(bus_wdata)); // R1

   AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr != IDX_ADDR) |=> $stable(idx)); // R11

endmodule

// File: rtl/ide_cfg_bank.sv
module ide_cfg_bank
   import ide_cfg_pkg::*;
#(
   parameter logic [7:0] BURST_RST  = 8'h40,
   parameter bit         SCRATCH_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [7:0]            idx,
   input  logic                  data_wr,
   input  logic [7:0]            wdata,
   output logic [NUM_BANK*8-1:0] bank_q,
   output logic [7:0]            scratch_q
);

   localparam logic [7:0] BANK_LAST = BANK_BASE + 8'(NUM_BANK - 1);

   logic       in_bank;
   logic [7:0] ofs;

   assign in_bank = (idx >= BANK_BASE) && (idx <= BANK_LAST);
   assign ofs     = idx - BANK_BASE;

   for (genvar i = 0; i < NUM_BANK; i++) begin : g_reg
      localparam logic [7:0] MASK = bank_wmask(i);
      localparam logic [7:0] RSTV = bank_reset(i, BURST_RST);
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= RSTV;
         else if (data_wr && in_bank && ofs == 8'(i))
            q <= (q & ~MASK) | (wdata & MASK);
      end
      assign bank_q[i*8 +: 8] = q;
   end

   if (SCRATCH_EN) begin : g_scratch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             scratch_q <= 8'h00;
         else if (data_wr && idx == SCRATCH_IDX) scratch_q <= wdata;
      end
      AST_SCRATCH_WR: assert property (@(posedge clk) disable iff (!rst_n)
         (data_wr && idx == SCRATCH_IDX) |=> scratch_q == $past(wdata)); // R8
   end else begin : g_no_scratch
      assign scratch_q = 8'h00;
   end

   AST_UNIMP_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !in_bank && idx != SCRATCH_IDX) |=> $stable(bank_q)); // R9

endmodule

// File: rtl/ide_cfg_rdmux.sv
module ide_cfg_rdmux
   import ide_cfg_pkg::*;
#(
   parameter int unsigned REVISION   = 2,
   parameter bit          ALT_LOC    = 1'b0,
   parameter bit          SCRATCH_EN = 1'b1
) (
   input  port_sel_e             sel,
   input  logic [7:0]            idx,
   input  logic [NUM_BANK*8-1:0] bank_q,
   input  logic [7:0]            scratch_q,
   input  logic                  irq_pri,
   input  logic                  irq_sec,
   output logic [7:0]            rd_byte
);

   localparam logic [1:0] REV_BITS = 2'(REVISION);

   logic [7:0] bank_byte;
   logic       bank_hit;

   always_comb begin
      bank_byte = 8'h00;
      bank_hit  = 1'b0;
      for (int i = 0; i < NUM_BANK; i++) begin
         if (idx == BANK_BASE + 8'(i)) begin
            bank_hit  = 1'b1;
            bank_byte = bank_q[i*8 +: 8];
            if (i == OFS_CFG) begin
               bank_byte[1:0] = REV_BITS;
               bank_byte[2]   = irq_pri;
               bank_byte[5]   = ALT_LOC;
            end
            if (i == OFS_SU23)
               bank_byte[4] = irq_sec;
         end
      end
   end

   always_comb begin
      rd_byte = 8'h00;
      case (sel)
         PORT_INDEX: rd_byte = idx;
         PORT_DATA: begin
            if (bank_hit)                              rd_byte = bank_byte;
            else if (SCRATCH_EN && idx == SCRATCH_IDX) rd_byte = scratch_q;
         end
         default: rd_byte = 8'h00;
      endcase
   end

endmodule

// File: rtl/ide_cfg_port.sv
module ide_cfg_port
   import ide_cfg_pkg::*;
#(
   parameter int unsigned ADDR_W     = 3,
   parameter int unsigned DATA_OFS   = 4,
   parameter int unsigned REVISION   = 2,
   parameter bit          ALT_LOC    = 1'b0,
   parameter logic [7:0]  BURST_RST  = 8'h40,
   parameter bit          SCRATCH_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              irq_pri,
   input  logic              irq_sec,
   output logic [7:0]        cmd_timing,
   output logic [23:0]       drv_setup,
   output logic [23:0]       drv_rw,
   output logic [7:0]        burst_size,
   output logic [3:0]        prefetch_off,
   output logic              chan2_en,
   output logic              fast_devsel
);

   if (REVISION < 1 || REVISION > 3) begin : g_bad_revision
      $error("REVISION must be 1..3");
   end
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr_w
      $error("ADDR_W must be 1..16");
   end
   if (DATA_OFS == 0 || DATA_OFS >= (1 << ADDR_W)) begin : g_bad_data_ofs
      $error("DATA_OFS must be non-zero and fit in ADDR_W bits");
   end

   port_sel_e             sel;
   logic [7:0]            idx;
   logic                  data_wr;
   logic [NUM_BANK*8-1:0] bank_q;
   logic [7:0]            scratch_q;
   logic [7:0]            rd_byte;
   logic [7:0]            ctrl_q;
   logic [7:0]            su23_q;

   ide_cfg_index #(.ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS)) i_index (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .sel(sel), .idx(idx), .data_wr(data_wr)
   );

   ide_cfg_bank #(.BURST_RST(BURST_RST), .SCRATCH_EN(SCRATCH_EN)) i_bank (
      .clk(clk), .rst_n(rst_n), .idx(idx), .data_wr(data_wr),
      .wdata(bus_wdata), .bank_q(bank_q), .scratch_q(scratch_q)
   );

   ide_cfg_rdmux #(.REVISION(REVISION), .ALT_LOC(ALT_LOC),
                   .SCRATCH_EN(SCRATCH_EN)) i_rdmux (
      .sel(sel), .idx(idx), .bank_q(bank_q), .scratch_q(scratch_q),
      .irq_pri(irq_pri), .irq_sec(irq_sec), .rd_byte(rd_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rdata <= 8'h00;
      else        bus_rdata <= bus_rd ? rd_byte : 8'h00;
   end

   assign ctrl_q       = bank_q[OFS_CTRL*8 +: 8];
   assign su23_q       = bank_q[OFS_SU23*8 +: 8];
   assign cmd_timing   = bank_q[OFS_CMD*8 +: 8];
   assign drv_setup    = {su23_q, bank_q[OFS_SU1*8 +: 8], bank_q[OFS_SU0*8 +: 8]};
   assign drv_rw       = {bank_q[OFS_RW23*8 +: 8], bank_q[OFS_RW1*8 +: 8],
                          bank_q[OFS_RW0*8 +: 8]};
   assign burst_size   = bank_q[OFS_BURST*8 +: 8];
   assign prefetch_off = {su23_q[3], su23_q[2], ctrl_q[7], ctrl_q[6]};
   assign chan2_en     = ctrl_q[3];
   assign fast_devsel  = (ctrl_q & FAST_DEVSEL_MASK) == FAST_DEVSEL_MASK;

   localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(DATA_OFS);

   AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> bus_rdata == 8'h00); // R11

   AST_REV_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == DATA_ADDR && idx == BANK_BASE)
      |=> bus_rdata[1:0] == 2'(REVISION)); // R2

   AST_IRQ_SEC: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == DATA_ADDR && idx == BANK_BASE + 8'(OFS_SU23))
      |=> bus_rdata[4] == $past(irq_sec)); // R6

   AST_BURST_RST: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(rst_n) && !$past(bus_wr)) |-> burst_size == BURST_RST); // R7

endmodule

// File: tb/test_ide_cfg_port.sv
module test_ide_cfg_port;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        irq_pri = 1'b0;
   logic        irq_sec = 1'b0;
   logic [7:0]  cmd_timing;
   logic [23:0] drv_setup;
   logic [23:0] drv_rw;
   logic [7:0]  burst_size;
   logic [3:0]  prefetch_off;
   logic        chan2_en;
   logic        fast_devsel;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   ide_cfg_port i_ide_cfg_port (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_pri(irq_pri), .irq_sec(irq_sec), .cmd_timing(cmd_timing),
      .drv_setup(drv_setup), .drv_rw(drv_rw), .burst_size(burst_size),
      .prefetch_off(prefetch_off), .chan2_en(chan2_en),
      .fast_devsel(fast_devsel)
   );

   task automatic check(input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: one expected byte per read strobe
   always @(posedge clk) begin
      if (bus_rd) begin
         #1;
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R11: actual %h expected none (empty scoreboard)", bus_rdata);
         end else begin
            check(tag_q.pop_front(), {24'h0, bus_rdata}, {24'h0, exp_q.pop_front()});
         end
      end
   end

   task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, input logic [7:0] exp,
                           input string tag);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic reg_write(input logic [7:0] idx, input logic [7:0] d);
      bus_write(3'd0, idx);
      bus_write(3'd4, d);
   endtask

   task automatic reg_read(input logic [7:0] idx, input logic [7:0] exp,
                           input string tag);
      bus_write(3'd0, idx);
      bus_read(3'd4, exp, tag);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 / R7 reset state
      check("R10 rdata", {24'h0, bus_rdata}, 32'h0);
      check("R10 cmd_timing", {24'h0, cmd_timing}, 32'h0);
      check("R10 drv_setup", {8'h0, drv_setup}, 32'h0);
      check("R10 drv_rw", {8'h0, drv_rw}, 32'h0);
      check("R10 flags", {29'h0, prefetch_off == 0, chan2_en, fast_devsel}, 32'h4);
      check("R7 burst reset", {24'h0, burst_size}, 32'h40);
      bus_read(3'd0, 8'h00, "R10 index reset");

      // R2 configuration byte
      reg_read(8'h50, 8'h02, "R2 cfg revision");
      irq_pri = 1'b1;
      reg_read(8'h50, 8'h06, "R2 cfg irq_pri");
      irq_pri = 1'b0;
      reg_write(8'h50, 8'hFF);
      reg_read(8'h50, 8'hDA, "R2 cfg writable mask");
      reg_write(8'h50, 8'h00);
      reg_read(8'h50, 8'h02, "R2 cfg clear");

      // R3 control byte
      reg_write(8'h51, 8'h08);
      check("R3 chan2_en", {31'h0, chan2_en}, 32'h1);
      reg_write(8'h51, 8'hC0);
      check("R3 prefetch_off", {28'h0, prefetch_off}, 32'h3);
      check("R3 chan2_en off", {31'h0, chan2_en}, 32'h0);
      reg_read(8'h51, 8'hC0, "R3 ctrl readback");

      // R4 fast device select
      reg_write(8'h51, 8'h27);
      check("R4 fast on", {31'h0, fast_devsel}, 32'h1);
      reg_write(8'h51, 8'h07);
      check("R4 fast partial", {31'h0, fast_devsel}, 32'h0);
      reg_write(8'h51, 8'h2F);
      check("R4 fast superset", {31'h0, fast_devsel}, 32'h1);
      reg_write(8'h51, 8'h00);
      check("R4 fast off", {31'h0, fast_devsel}, 32'h0);

      // R5 / R6 timing bytes
      reg_write(8'h52, 8'hA1);
      reg_write(8'h53, 8'hB2);
      reg_write(8'h54, 8'hC3);
      reg_write(8'h55, 8'hD4);
      reg_write(8'h56, 8'hE5);
      reg_write(8'h57, 8'hFF);
      reg_write(8'h58, 8'h96);
      check("R5 cmd_timing", {24'h0, cmd_timing}, 32'hA1);
      check("R5 drv_setup", {8'h0, drv_setup}, 32'hEFD4B2);
      check("R5 drv_rw", {8'h0, drv_rw}, 32'h96E5C3);
      check("R6 prefetch_off", {28'h0, prefetch_off}, 32'hC);
      reg_read(8'h52, 8'hA1, "R5 read 52");
      reg_read(8'h56, 8'hE5, "R5 read 56");
      reg_read(8'h58, 8'h96, "R5 read 58");
      reg_read(8'h57, 8'hEF, "R6 su23 irq low");
      irq_sec = 1'b1;
      reg_read(8'h57, 8'hFF, "R6 su23 irq high");
      reg_write(8'h57, 8'h00);
      reg_read(8'h57, 8'h10, "R6 irq ignores write");
      check("R6 prefetch_off clear", {28'h0, prefetch_off}, 32'h0);
      irq_sec = 1'b0;

      // R7 burst
      reg_write(8'h59, 8'h80);
      check("R7 burst out", {24'h0, burst_size}, 32'h80);
      reg_read(8'h59, 8'h80, "R7 burst readback");

      // R8 scratch
      reg_write(8'h5B, 8'hBD);
      reg_read(8'h5B, 8'hBD, "R8 scratch BD");
      reg_write(8'h5B, 8'h00);
      reg_read(8'h5B, 8'h00, "R8 scratch 00");

      // R9 unimplemented indices
      reg_write(8'h5A, 8'h55);
      reg_read(8'h5A, 8'h00, "R9 read 5A");
      reg_write(8'h00, 8'h33);
      reg_read(8'h00, 8'h00, "R9 read 00");
      reg_read(8'hFF, 8'h00, "R9 read FF");
      reg_read(8'h59, 8'h80, "R9 burst untouched");
      check("R9 timing untouched", {8'h0, drv_rw}, 32'h96E5C3);

      // R1 index readback, R11 stray offsets
      bus_write(3'd0, 8'h53);
      bus_read(3'd0, 8'h53, "R1 index readback");
      bus_read(3'd2, 8'h00, "R11 stray read");
      bus_write(3'd2, 8'h51);
      bus_read(3'd0, 8'h53, "R11 stray write keeps index");
      bus_read(3'd4, 8'hB2, "R11 data via kept index");
      @(negedge clk);
      check("R11 rdata idle", {24'h0, bus_rdata}, 32'h0);

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule